// File: doc/BRIEF.md
# Interleaved Multi-Cycle Carry-Select Resolver

This block turns two wide redundant (carry-save) numbers into plain binary. Each number arrives as a pair of `WIDTH`-bit words, a sum word and a carry word. The result is their ordinary sum. A pulse on `start` while the block is idle captures all four operand words into internal registers. The block then resolves the two additions in pieces rather than in one wide adder. On each clock it handles one chunk of `WORDS * WORD_W` bits. Inside the chunk, each `WORD_W`-bit word computes its sum for both values of the incoming carry, and the real carry picks one of the two.

One chunk stage serves both additions, and they take turns on alternating clocks. Each addition keeps its own carry register between chunks, and that register is cleared at every start. An internal chunk pointer walks from the least significant chunk to the most significant one. The last chunk is padded with zeros when `WIDTH` is not a multiple of the chunk width. A full conversion takes `2 * ceil(WIDTH / (WORDS * WORD_W))` clocks after the start edge, which is 46 clocks with the defaults (1024, 15, 3). At the end, `done` pulses for one clock. The results and carry-outs then stay steady until the next conversion starts writing.

Top module: `ilv_cselect_adder`

## Requirements
- R1: During and right after synchronous reset, `busy`, `done`, `res_a`, `res_b`, `cout_a` and `cout_b` are all zero.
- R2: A `start` that is high at a rising edge while `busy` is low captures `a_sum`, `a_car`, `b_sum` and `b_car`, and `busy` reads high after that edge.
- R3: `done` is high for exactly one clock, after the edge that ends the `2*ceil(WIDTH/(WORDS*WORD_W))`-th busy cycle that follows the start edge. `busy` falls at that same edge.
- R4: When `done` is high, `res_a` holds bits `WIDTH-1:0` of `a_sum + a_car` and `cout_a` holds bit `WIDTH` of that sum.
- R5: When `done` is high, `res_b` and `cout_b` hold the same for `b_sum + b_car`, with no influence from the A operands.
- R6: A carry produced in one chunk reaches the next chunk of the same addition. For example, all-ones plus one gives a zero result with carry-out 1.
- R7: A `start` pulse while `busy` is high is ignored. The running conversion finishes with its original operands and on its original schedule.
- R8: When `WIDTH` is not a multiple of the chunk width, the last chunk is treated as zero above bit `WIDTH-1`, and the carry out of bit `WIDTH-1` appears on the carry-out port.
- R9: While `busy` is low and `start` is low, results and carry-outs do not change.
- R10: Each start clears the chunk carry of both additions, so a carry left over from the previous conversion never enters the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and begin, honoured only while idle |
| a_sum | input | WIDTH | Sum word of operand A |
| a_car | input | WIDTH | Carry word of operand A |
| b_sum | input | WIDTH | Sum word of operand B |
| b_car | input | WIDTH | Carry word of operand B |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-clock pulse when both results are final |
| res_a | output | WIDTH | Binary value of A, low WIDTH bits |
| cout_a | output | 1 | Bit WIDTH of the A sum |
| res_b | output | WIDTH | Binary value of B, low WIDTH bits |
| cout_b | output | 1 | Bit WIDTH of the B sum |

## Verification
All-ones plus one forces a carry through every chunk of one addition while the other addition carries nothing. A design that shared or dropped the chunk carry would leave ones in the upper chunks or corrupt the quiet operand. Operands with only the top bit set aim at the zero-padded last chunk. A design that picked the carry-out from the wrong bit would report carry 0. A conversion that ends with a carry, followed by zero plus zero, exposes a carry that was not cleared at start. A second `start` in the middle of a conversion, with different operands, shows whether the block restarts or re-captures its inputs.

// File: rtl/ilv_add_pkg.sv
package ilv_add_pkg;

  // which of the two interleaved additions owns the current cycle
  typedef enum logic {
    SLOT_A = 1'b0,
    SLOT_B = 1'b1
  } slot_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/cs_word.sv
// One word of the chunk: both carry-in outcomes are formed in parallel,
// the arriving carry only drives the final select.
module cs_word #(
  parameter int W = 15
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0] sum_c0;
  logic [W:0] sum_c1;

  assign sum_c0 = {1'b0, x} + {1'b0, y};
  assign sum_c1 = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, 1'b1};

  always_comb begin
    if (ci) begin
      {co, s} = sum_c1;
    end else begin
      {co, s} = sum_c0;
    end
  end

endmodule

// File: rtl/cs_chunk.sv
// K words chained by their select carries: one chunk per clock.
module cs_chunk #(
  parameter int W = 15,
  parameter int K = 3,
  localparam int CW = W * K
) (
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic          ci,
  output logic [CW-1:0] s,
  output logic          co
);

  logic [K:0] chain;

  assign chain[0] = ci;

  for (genvar g = 0; g < K; g++) begin : g_word
    cs_word #(.W(W)) u_word (
      .x (x[g*W +: W]),
      .y (y[g*W +: W]),
      .ci(chain[g]),
      .s (s[g*W +: W]),
      .co(chain[g+1])
    );
  end

  assign co = chain[K];

endmodule

// File: rtl/ilv_seq.sv
// Sequencer: alternates the two slots, advances the chunk pointer after
// slot B, and raises a one-clock completion pulse.
module ilv_seq
  import ilv_add_pkg::*;
#(
  parameter int NCH   = 23,
  localparam int PTR_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output slot_e            slot,
  output logic [PTR_W-1:0] ptr,
  output logic             last
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NCH - 1);

  assign last = (ptr == PTR_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      slot <= SLOT_A;
      ptr  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          slot <= SLOT_A;
          ptr  <= '0;
        end
      end else begin
        if (slot == SLOT_B) begin
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            ptr <= ptr + 1'b1;
          end
          slot <= SLOT_A;
        end else begin
          slot <= SLOT_B;
        end
      end
    end
  end

endmodule

// File: rtl/ilv_cselect_adder.sv
module ilv_cselect_adder
  import ilv_add_pkg::*;
#(
  parameter int WIDTH  = 1024,
  parameter int WORD_W = 15,
  parameter int WORDS  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] a_sum,
  input  logic [WIDTH-1:0] a_car,
  input  logic [WIDTH-1:0] b_sum,
  input  logic [WIDTH-1:0] b_car,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] res_a,
  output logic             cout_a,
  output logic [WIDTH-1:0] res_b,
  output logic             cout_b
);

  localparam int CW     = WORD_W * WORDS;
  localparam int NCH    = ceil_div(WIDTH, CW);
  localparam int PW     = NCH * CW;
  localparam int PTR_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int TOPBIT = WIDTH - (NCH - 1) * CW;

  slot_e            slot;
  logic [PTR_W-1:0] ptr;
  logic             last;
  logic             load;

  logic [PW-1:0] opx_a, opy_a, opx_b, opy_b;
  logic [PW-1:0] acc_a, acc_b;
  logic          cy_a, cy_b;

  logic [CW-1:0] cx, cyv, cs;
  logic          cin, cco;
  logic [CW:0]   cfull;

  ilv_seq #(.NCH(NCH)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .done (done),
    .slot (slot),
    .ptr  (ptr),
    .last (last)
  );

  assign load = start && !busy;

  // operand capture, zero-padded up to a whole number of chunks
  always_ff @(posedge clk) begin
    if (rst) begin
      opx_a <= '0;
      opy_a <= '0;
      opx_b <= '0;
      opy_b <= '0;
    end else if (load) begin
      opx_a <= PW'(a_sum);
      opy_a <= PW'(a_car);
      opx_b <= PW'(b_sum);
      opy_b <= PW'(b_car);
    end
  end

  // chunk selection for the slot owning this cycle
  always_comb begin
    if (slot == SLOT_B) begin
      cx  = opx_b[int'(ptr)*CW +: CW];
      cyv = opy_b[int'(ptr)*CW +: CW];
      cin = cy_b;
    end else begin
      cx  = opx_a[int'(ptr)*CW +: CW];
      cyv = opy_a[int'(ptr)*CW +: CW];
      cin = cy_a;
    end
  end

  cs_chunk #(.W(WORD_W), .K(WORDS)) u_chunk (
    .x (cx),
    .y (cyv),
    .ci(cin),
    .s (cs),
    .co(cco)
  );

  assign cfull = {cco, cs};

  // per-slot carry, partial results and carry-out
  always_ff @(posedge clk) begin
    if (rst) begin
      cy_a   <= 1'b0;
      cy_b   <= 1'b0;
      acc_a  <= '0;
      acc_b  <= '0;
      cout_a <= 1'b0;
      cout_b <= 1'b0;
    end else if (load) begin
      cy_a <= 1'b0;
      cy_b <= 1'b0;
    end else if (busy) begin
      if (slot == SLOT_B) begin
        acc_b[int'(ptr)*CW +: CW] <= cs;
        cy_b <= cco;
        if (last) begin
          cout_b <= cfull[TOPBIT];
        end
      end else begin
        acc_a[int'(ptr)*CW +: CW] <= cs;
        cy_a <= cco;
        if (last) begin
          cout_a <= cfull[TOPBIT];
        end
      end
    end
  end

  assign res_a = acc_a[WIDTH-1:0];
  assign res_b = acc_b[WIDTH-1:0];

  if (PW > WIDTH) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^{acc_a[PW-1:WIDTH], acc_b[PW-1:WIDTH]};
  end

endmodule

// File: rtl/ilv_cselect_adder_chk.sv
module ilv_cselect_adder_chk #(
  parameter int WIDTH  = 1024,
  parameter int WORD_W = 15,
  parameter int WORDS  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] res_a,
  input logic [WIDTH-1:0] res_b,
  input logic             cout_a,
  input logic             cout_b
);

  localparam int CW  = WORD_W * WORDS;
  localparam int TOT = 2 * ((WIDTH + CW - 1) / CW);

  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= 0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + 1;
    end else begin
      busy_cnt <= 0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  assert_done_window_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cnt == TOT));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_cnt < TOT - 1) |=> busy);

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(res_a) && $stable(res_b) &&
                           $stable(cout_a) && $stable(cout_b)));

endmodule

bind ilv_cselect_adder ilv_cselect_adder_chk #(
  .WIDTH (WIDTH),
  .WORD_W(WORD_W),
  .WORDS (WORDS)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .res_a (res_a),
  .res_b (res_b),
  .cout_a(cout_a),
  .cout_b(cout_b)
);

// File: tb/test_ilv_cselect_adder.sv
module test_ilv_cselect_adder;

  localparam int N      = 1024;
  localparam int WW     = 15;
  localparam int KK     = 3;
  localparam int TOT    = 2 * ((N + WW * KK - 1) / (WW * KK));
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] a_sum = '0, a_car = '0, b_sum = '0, b_car = '0;
  logic         busy, done, cout_a, cout_b;
  logic [N-1:0] res_a, res_b;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  logic       m_busy = 1'b0;
  logic       m_done = 1'b0;
  int         m_cnt  = 0;
  logic [N:0] pend_a = '0, pend_b = '0;
  logic [N:0] exp_a  = '0, exp_b  = '0;

  always #(PERIOD/2) clk = ~clk;

  ilv_cselect_adder #(.WIDTH(N), .WORD_W(WW), .WORDS(KK)) i_ilv_cselect_adder (
    .clk(clk), .rst(rst), .start(start),
    .a_sum(a_sum), .a_car(a_car), .b_sum(b_sum), .b_car(b_car),
    .busy(busy), .done(done),
    .res_a(res_a), .cout_a(cout_a), .res_b(res_b), .cout_b(cout_b)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every clock at the falling edge, then advance the model
  always @(negedge clk) begin
    logic nd;
    chk(busy == m_busy, "R2", "busy", N'(busy), N'(m_busy));
    chk(done == m_done, "R3", "done", N'(done), N'(m_done));
    if (!m_busy) begin
      chk({cout_a, res_a} == exp_a, "R4", "result A", {cout_a, res_a}, exp_a);
      chk({cout_b, res_b} == exp_b, "R5", "result B", {cout_b, res_b}, exp_b);
    end
    nd = 1'b0;
    if (rst) begin
      m_busy = 1'b0;
      m_cnt  = 0;
      exp_a  = '0;
      exp_b  = '0;
    end else if (m_busy) begin
      if (m_cnt == TOT - 1) begin
        m_busy = 1'b0;
        nd     = 1'b1;
        exp_a  = pend_a;
        exp_b  = pend_b;
      end else begin
        m_cnt++;
      end
    end else if (start) begin
      m_busy = 1'b1;
      m_cnt  = 0;
      pend_a = {1'b0, a_sum} + {1'b0, a_car};
      pend_b = {1'b0, b_sum} + {1'b0, b_car};
    end
    m_done = nd;
  end

  function automatic logic [N-1:0] rnd();
    logic [N-1:0] v;
    for (int i = 0; i < N; i += 32) v[i +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_op(input logic [N-1:0] x0, input logic [N-1:0] y0,
                        input logic [N-1:0] x1, input logic [N-1:0] y1);
    @(posedge clk); #1;
    a_sum = x0; a_car = y0; b_sum = x1; b_car = y1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (TOT + 2) @(posedge clk);
    #2;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(!busy && !done && res_a == '0 && res_b == '0 && !cout_a && !cout_b,
        "R1", "reset state", {cout_a, res_a}, '0);
    #1 rst = 1'b0;

    // random operand pairs
    for (int t = 0; t < 6; t++) run_op(rnd(), rnd(), rnd(), rnd());

    // R6: ripple through every chunk on A, B quiet
    run_op('1, N'(1), N'(5), N'(7));
    chk(res_a == '0 && cout_a, "R6", "all-ones plus one", {cout_a, res_a}, {1'b1, {N{1'b0}}});
    chk({cout_b, res_b} == (N+1)'(12), "R5", "B untouched by A carry", {cout_b, res_b}, (N+1)'(12));

    // all ones on both
    run_op('1, '1, '1, '1);
    chk({cout_b, res_b} == {1'b1, {(N-1){1'b1}}, 1'b0}, "R4", "all-ones pair",
        {cout_b, res_b}, {1'b1, {(N-1){1'b1}}, 1'b0});

    // R10: leftover carry must not enter next conversion
    run_op('0, '0, '0, '0);
    chk({cout_a, res_a} == '0 && {cout_b, res_b} == '0, "R10", "carry cleared",
        {cout_a, res_a}, '0);

    // R8: carry out of the top bit in the padded last chunk
    run_op({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}}, '0);
    chk(cout_a && res_a == '0, "R8", "top-bit carry A", {cout_a, res_a}, {1'b1, {N{1'b0}}});
    chk(!cout_b && res_b == {1'b1, {(N-1){1'b0}}}, "R8", "top bit B",
        {cout_b, res_b}, {2'b01, {(N-1){1'b0}}});

    // R7: start while busy with other operands is ignored
    @(posedge clk); #1;
    a_sum = N'(100); a_car = N'(23); b_sum = N'(9); b_car = N'(1);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    a_sum = '1; a_car = '1; b_sum = '1; b_car = '1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (TOT) @(posedge clk);
    #2;
    chk({cout_a, res_a} == (N+1)'(123), "R7", "mid-run start A", {cout_a, res_a}, (N+1)'(123));
    chk({cout_b, res_b} == (N+1)'(10), "R7", "mid-run start B", {cout_b, res_b}, (N+1)'(10));

    // R9: idle hold
    repeat (5) @(posedge clk);
    #2;
    chk({cout_a, res_a} == (N+1)'(123), "R9", "idle hold", {cout_a, res_a}, (N+1)'(123));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule